// File: doc/BRIEF.md
# Serial Port Status Word and Interrupt Request

This block keeps the eight-bit status word of an asynchronous serial port and drives the active-low interrupt request line toward the host processor. It merges three groups of conditions into one byte. The first group is the transmit holding register empty flag and the receive holding register full flag. The second is the live level of two active-low modem lines: data set ready and carrier detect. The third is the three receive error flags: overrun, framing and parity.

Four of these sources can pull the interrupt line low. These are the two modem lines, which raise a latched event on any change of level, and the two holding-register flags, each of which needs its own enable from the command register. The error flags never raise an interrupt. The host reads the word through a selected read port. Reading the status word acknowledges a modem event. Reading the receive data register clears the receive flags, and writing the transmit data register clears the empty flag. The block has an asynchronous hardware reset and a synchronous program reset, and the two give different results.

Top module: `uart_stat_irq`

## Requirements
- R1: After hardware reset the status word is {0, dsr_n_i, dcd_n_i, 1, 0, 0, 0, 0}, bit 7 first, and irq_n_o is high when both enables are off.
- R2: Bit 6 equals the level of dsr_n_i and bit 5 equals the level of dcd_n_i in the same cycle (1 = not ready / not detected).
- R3: A receive load (rx_load_i) with bit 3 clear sets bit 3 and copies fe_i into bit 1 and pe_i into bit 0. A receive data read (sel_i=1, we_i=0, addr_i=0) clears bits 3 to 0. A load in the same cycle as a read wins.
- R4: A receive load while bit 3 is set sets overrun (bit 2) and leaves bits 3, 1 and 0 unchanged.
- R5: A transfer pulse (tx_xfer_i) sets bit 4. A transmit data write (sel_i=1, we_i=1, addr_i=0) clears it, and the write wins when both come in one cycle.
- R6: Bit 3 raises bit 7 and drives irq_n_o low only while rx_irq_en_i is 1.
- R7: Bit 4 raises bit 7 only while tx_irq_mode_i is 2'b01. Every other code masks it.
- R8: Any change of level on dsr_n_i or dcd_n_i, from the second cycle after reset on, latches a pending modem event that sets bit 7. A status read (sel_i=1, we_i=0, addr_i=1) clears the event unless a new change comes in the same cycle. Bit 7 stays set while an enabled holding-register source is active.
- R9: Bits 2 to 0 never set bit 7 or pull irq_n_o low.
- R10: A program reset pulse clears bit 2 only, and it wins over an overrun in the same cycle. All other bits are unchanged.
- R11: rdata_o carries the status word during a status read and is 0 otherwise.
- R12: irq_n_o is always the inverse of bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| prog_rst_i | input | 1 | Program reset pulse |
| sel_i | input | 1 | Chip selected during the clock high phase |
| we_i | input | 1 | 1 = host write, 0 = host read |
| addr_i | input | 2 | Register select (0 = data, 1 = status) |
| dsr_n_i | input | 1 | Data set ready, active low |
| dcd_n_i | input | 1 | Carrier detect, active low |
| rx_load_i | input | 1 | Receiver moves a character into its holding register |
| fe_i | input | 1 | Framing error of the loaded character |
| pe_i | input | 1 | Parity error of the loaded character |
| tx_xfer_i | input | 1 | Transmitter moves its holding register into the shifter |
| rx_irq_en_i | input | 1 | Receive-full interrupt enable |
| tx_irq_mode_i | input | 2 | Transmit control field, 2'b01 enables the empty interrupt |
| status_o | output | 8 | Status word |
| rdata_o | output | 8 | Read port data |
| irq_n_o | output | 1 | Interrupt request, active low |

## Verification
Every stored flag changes on the clock edge that samples its stimulus, so each result is due one edge after the inputs are applied. Bits 6 and 5, bit 7's response to an enable change, irq_n_o and rdata_o follow their inputs with no edge at all. The driver applies a stimulus on a falling edge and queues the word the model predicts after the next rising edge. The monitor compares one nanosecond after that rising edge, while the inputs are still held. This one placement therefore covers both the registered results and the zero-latency ones.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
  localparam int unsigned STAT_W = 8;

  localparam int unsigned B_IRQ  = 7;
  localparam int unsigned B_DSR  = 6;
  localparam int unsigned B_DCD  = 5;
  localparam int unsigned B_TXE  = 4;
  localparam int unsigned B_RXF  = 3;
  localparam int unsigned B_OVR  = 2;
  localparam int unsigned B_FE   = 1;
  localparam int unsigned B_PE   = 0;

  localparam logic [1:0] TX_IRQ_ON = 2'b01;

  typedef struct packed {
    logic full;
    logic ovr;
    logic fe;
    logic pe;
  } rx_flags_t;
endpackage

// File: rtl/ust_modem_watch.sv
module ust_modem_watch #(
  parameter int unsigned N_LINES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] lines_i,
  input  logic               ack_i,
  output logic               pend_o
);
  logic               armed_q;
  logic [N_LINES-1:0] prev_q;
  logic [N_LINES-1:0] chg;
  logic               any_chg;
  logic               pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[g] <= 1'b0;
      else         prev_q[g] <= lines_i[g];
    end
    assign chg[g] = armed_q && (lines_i[g] != prev_q[g]);
  end

  assign any_chg = |chg;

  // a fresh change beats the acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= 1'b0;
    else if (any_chg) pend_q <= 1'b1;
    else if (ack_i)   pend_q <= 1'b0;
  end

  assign pend_o = pend_q;

  // R8
  chg_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_chg |=> pend_o);

  // R8
  ack_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !any_chg) |=> !pend_o);
endmodule

// File: rtl/ust_rx_flags.sv
module ust_rx_flags
  import uart_stat_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      load_i,
  input  logic      fe_i,
  input  logic      pe_i,
  input  logic      data_rd_i,
  input  logic      prog_rst_i,
  output rx_flags_t flags_o
);
  rx_flags_t q, d;

  always_comb begin
    d = q;
    if (data_rd_i) begin
      d = '0;
    end
    if (load_i) begin
      if (d.full) begin
        d.ovr = 1'b1;
      end else begin
        d.full = 1'b1;
        d.fe   = fe_i;
        d.pe   = pe_i;
      end
    end
    if (prog_rst_i) d.ovr = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= d;
  end

  assign flags_o = q;

  // R3
  rd_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd_i && !load_i) |=> (flags_o == '0));

  // R4
  ovr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && flags_o.full && !data_rd_i && !prog_rst_i) |=> (flags_o.ovr && flags_o.full));

  // R4
  ovr_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && flags_o.full && !data_rd_i) |=> ($stable(flags_o.fe) && $stable(flags_o.pe)));

  // R10
  prst_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_rst_i |=> !flags_o.ovr);
endmodule

// File: rtl/ust_tx_flag.sv
module ust_tx_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic xfer_i,
  input  logic data_wr_i,
  output logic empty_o
);
  logic empty_q;

  // a host write refills the holding register after the transfer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        empty_q <= 1'b1;
    else if (data_wr_i) empty_q <= 1'b0;
    else if (xfer_i)    empty_q <= 1'b1;
  end

  assign empty_o = empty_q;

  // R5
  wr_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr_i |=> !empty_o);

  // R5
  xfer_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i && !data_wr_i) |=> empty_o);
endmodule

// File: rtl/ust_irq_ctrl.sv
module ust_irq_ctrl
  import uart_stat_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pend_i,
  input  logic       full_i,
  input  logic       empty_i,
  input  logic       rx_en_i,
  input  logic [1:0] tx_mode_i,
  output logic       irq_o
);
  logic rx_src, tx_src;

  assign rx_src = full_i && rx_en_i;
  assign tx_src = empty_i && (tx_mode_i == TX_IRQ_ON);
  assign irq_o  = pend_i || rx_src || tx_src;

  // R7
  tx_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_mode_i != TX_IRQ_ON && !pend_i && !rx_src) |-> !irq_o);

  // R6
  rx_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_en_i && !pend_i && !tx_src) |-> !irq_o);
endmodule

// File: rtl/uart_stat_irq.sv
module uart_stat_irq
  import uart_stat_pkg::*;
#(
  parameter int unsigned     ADDR_W    = 2,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 'd0,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'd1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_rst_i,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              dsr_n_i,
  input  logic              dcd_n_i,
  input  logic              rx_load_i,
  input  logic              fe_i,
  input  logic              pe_i,
  input  logic              tx_xfer_i,
  input  logic              rx_irq_en_i,
  input  logic [1:0]        tx_irq_mode_i,
  output logic [STAT_W-1:0] status_o,
  output logic [STAT_W-1:0] rdata_o,
  output logic              irq_n_o
);
  localparam int unsigned N_MODEM = 2;

  logic      data_rd, data_wr, stat_rd;
  logic      pend, empty, irq;
  rx_flags_t rxf;

  assign data_rd = sel_i && !we_i && (addr_i == DATA_ADDR);
  assign data_wr = sel_i &&  we_i && (addr_i == DATA_ADDR);
  assign stat_rd = sel_i && !we_i && (addr_i == STAT_ADDR);

  ust_modem_watch #(.N_LINES(N_MODEM)) u_modem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lines_i ({dsr_n_i, dcd_n_i}),
    .ack_i   (stat_rd),
    .pend_o  (pend)
  );

  ust_rx_flags u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (rx_load_i),
    .fe_i       (fe_i),
    .pe_i       (pe_i),
    .data_rd_i  (data_rd),
    .prog_rst_i (prog_rst_i),
    .flags_o    (rxf)
  );

  ust_tx_flag u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .xfer_i    (tx_xfer_i),
    .data_wr_i (data_wr),
    .empty_o   (empty)
  );

  ust_irq_ctrl u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pend_i    (pend),
    .full_i    (rxf.full),
    .empty_i   (empty),
    .rx_en_i   (rx_irq_en_i),
    .tx_mode_i (tx_irq_mode_i),
    .irq_o     (irq)
  );

  always_comb begin
    status_o        = '0;
    status_o[B_IRQ] = irq;
    status_o[B_DSR] = dsr_n_i;
    status_o[B_DCD] = dcd_n_i;
    status_o[B_TXE] = empty;
    status_o[B_RXF] = rxf.full;
    status_o[B_OVR] = rxf.ovr;
    status_o[B_FE]  = rxf.fe;
    status_o[B_PE]  = rxf.pe;
  end

  assign rdata_o = stat_rd ? status_o : '0;
  assign irq_n_o = ~irq;

  // R9
  err_no_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend && !rx_irq_en_i && tx_irq_mode_i != TX_IRQ_ON && |status_o[B_OVR:B_PE])
      |-> irq_n_o);

  // R10
  prst_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_rst_i && !rx_load_i && !data_rd && !data_wr && !tx_xfer_i)
      |=> ($stable(status_o[B_TXE:B_RXF]) && $stable(status_o[B_FE:B_PE])));
endmodule

// File: tb/uart_stat_irq_tb.sv
`timescale 1ns/1ps
module uart_stat_irq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       prst = 1'b0, sel = 1'b0, we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       dsr_n = 1'b1, dcd_n = 1'b0;
  logic       rx_load = 1'b0, fe = 1'b0, pe = 1'b0, tx_xfer = 1'b0;
  logic       rx_en = 1'b0;
  logic [1:0] tx_mode = 2'b00;
  logic [7:0] status, rdata;
  logic       irq_n;

  always #2 clk = ~clk;

  uart_stat_irq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .prog_rst_i(prst), .sel_i(sel), .we_i(we),
    .addr_i(addr), .dsr_n_i(dsr_n), .dcd_n_i(dcd_n), .rx_load_i(rx_load),
    .fe_i(fe), .pe_i(pe), .tx_xfer_i(tx_xfer), .rx_irq_en_i(rx_en),
    .tx_irq_mode_i(tx_mode), .status_o(status), .rdata_o(rdata), .irq_n_o(irq_n)
  );

  int errors = 0;
  int checks = 0;

  typedef struct {
    logic [7:0] st;
    logic       irqn;
    logic [7:0] rd;
    string      tag;
  } exp_t;
  exp_t q[$];

  // staged stimulus
  logic       s_prst, s_sel, s_we, s_load, s_fe, s_pe, s_xfer, s_rxen;
  logic [1:0] s_addr, s_mode;
  logic       s_dsr, s_dcd;

  // model state
  logic m_full, m_ovr, m_fe, m_pe, m_empty, m_pend, m_armed, m_pdsr, m_pdcd;

  task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_full = 0; m_ovr = 0; m_fe = 0; m_pe = 0; m_empty = 1; m_pend = 0;
    m_armed = 0; m_pdsr = 0; m_pdcd = 0;
    s_prst = 0; s_sel = 0; s_we = 0; s_load = 0; s_fe = 0; s_pe = 0; s_xfer = 0;
    s_rxen = 0; s_addr = 0; s_mode = 0; s_dsr = dsr_n; s_dcd = dcd_n;
  endtask

  task automatic step(input string tag);
    logic rd_d, wr_d, rd_s, chg, irq;
    logic [7:0] st;
    exp_t e;
    @(negedge clk);
    prst = s_prst; sel = s_sel; we = s_we; addr = s_addr; dsr_n = s_dsr; dcd_n = s_dcd;
    rx_load = s_load; fe = s_fe; pe = s_pe; tx_xfer = s_xfer; rx_en = s_rxen; tx_mode = s_mode;
    rd_d = s_sel && !s_we && s_addr == 2'd0;
    wr_d = s_sel &&  s_we && s_addr == 2'd0;
    rd_s = s_sel && !s_we && s_addr == 2'd1;
    chg  = m_armed && (s_dsr != m_pdsr || s_dcd != m_pdcd);
    if (chg) m_pend = 1; else if (rd_s) m_pend = 0;
    if (rd_d) begin m_full = 0; m_ovr = 0; m_fe = 0; m_pe = 0; end
    if (s_load) begin
      if (m_full) m_ovr = 1;
      else begin m_full = 1; m_fe = s_fe; m_pe = s_pe; end
    end
    if (s_prst) m_ovr = 0;
    if (wr_d) m_empty = 0; else if (s_xfer) m_empty = 1;
    m_armed = 1; m_pdsr = s_dsr; m_pdcd = s_dcd;
    irq = m_pend || (m_full && s_rxen) || (m_empty && s_mode == 2'b01);
    st = {irq, s_dsr, s_dcd, m_empty, m_full, m_ovr, m_fe, m_pe};
    e.st = st; e.irqn = ~irq; e.rd = rd_s ? st : 8'h00; e.tag = tag;
    q.push_back(e);
    s_prst = 0; s_sel = 0; s_we = 0; s_load = 0; s_fe = 0; s_pe = 0; s_xfer = 0; s_addr = 0;
  endtask

  // monitor: one result per edge, sampled after the edge with inputs still held
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk8({e.tag, " status"}, status, e.st);
      chk8({"R12 ", e.tag, " irq_n"}, {7'd0, irq_n}, {7'd0, e.irqn});
      chk8({"R11 ", e.tag, " rdata"}, rdata, e.rd);
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 R2: reset word with dsr high, dcd low
    chk8("R1 R2 reset status", status, 8'h50);
    chk8("R1 reset irq_n", {7'd0, irq_n}, 8'h01);
    rst_n = 1'b1;
    model_reset();

    step("R1 idle after reset");
    s_dcd = 1;                     step("R8 dcd change latches");
    s_sel = 1; s_addr = 1;         step("R8 status read acks");
    s_load = 1; s_fe = 1;          step("R3 load sets full+fe, R6 masked");
    s_load = 1; s_pe = 1;          step("R4 overrun keeps fe/pe");
    s_prst = 1;                    step("R10 prog reset clears ovr only");
    s_rxen = 1;                    step("R6 rx enable raises irq");
    s_sel = 1; s_addr = 0;         step("R3 data read clears rx bits");
    s_rxen = 0; s_load = 1; s_pe = 1; step("R9 parity err no irq");
    s_prst = 1; s_load = 1;        step("R10 prst beats overrun");
    s_mode = 2'b10;                step("R7 mode 10 masks tx");
    s_mode = 2'b11;                step("R7 mode 11 masks tx");
    s_mode = 2'b01;                step("R7 mode 01 tx irq");
    s_sel = 1; s_we = 1;           step("R5 tx write clears empty");
    s_xfer = 1; s_sel = 1; s_we = 1; step("R5 write wins over xfer");
    s_xfer = 1;                    step("R5 xfer sets empty");
    s_mode = 2'b00;                step("R7 mask again");
    s_dsr = 0;                     step("R2 R8 dsr change");
    s_dcd = 0; s_sel = 1; s_addr = 1; step("R8 change beats ack");
    s_sel = 1; s_addr = 1;         step("R8 ack clears");
    s_rxen = 1; s_sel = 1; s_addr = 1; step("R8 level source holds irq");
    s_prst = 1;                    step("R10 prst no other effect");
    s_sel = 1; s_addr = 0; s_load = 1; s_fe = 1; step("R3 load wins over read");
    s_rxen = 0;                    step("R6 disable drops irq");
    s_sel = 1; s_addr = 2;         step("R11 other address reads 0");
    step("final idle");
    repeat (3) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule